// File: doc/BRIEF.md
# Multiplexed Hysteresis Classifier with Tick-Counted Debounce

This block turns a signed measured level for each of many input channels into a clean logic bit. Levels reach it over several parallel lanes. Each valid lane carries a channel number and the level word for that channel. The level word may be a DC average or an AC RMS figure; the block treats both the same way. For each visit, the block compares the level against that channel's own pair of thresholds. The comparison has a dead band in which the channel keeps its present state.

The classified bit then goes through a debounce filter. A pending change is accepted only after it has been seen across a programmed number of 0.1 ms ticks. All per-channel state lives in register arrays indexed by channel number: the output bit, the pending counter, a flag that records a tick seen since the last visit, and the configuration. The block reads this state, updates it and writes it back in a single clock for every lane sample. The output bit of a channel therefore changes on the clock edge that ends the cycle in which that channel was presented.

Configuration is written one channel at a time through a write strobe. A write takes effect for visits in later cycles.

Top module: `lvl_deb_top`

## Requirements
- R1: On a visit, a level strictly greater than the channel's high threshold classifies as 1. Levels and thresholds are compared as signed 16-bit two's-complement numbers.
- R2: On a visit, a level strictly below the channel's low threshold classifies as 0.
- R3: A level between the thresholds, inclusive of both, classifies as the channel's present output bit, so the output holds.
- R4: When a channel's low threshold is above its high threshold, both thresholds act as one threshold at the high value. Above it gives 1, below it gives 0, and equal to it holds.
- R5: With a debounce length of 0, the output bit of a visited channel takes the classified value at the clock edge that ends the visit cycle.
- R6: With a debounce length N > 0, a visit whose classification differs from the output advances the channel's counter by one, but only if a tick was seen. A tick counts if it arrived since that channel's previous visit (or since reset), or in the visit cycle itself. When the counter reaches N, the output takes the classified value and the counter clears.
- R7: A visit whose classification agrees with the output clears the channel's counter.
- R8: Low threshold, high threshold and debounce length (0 to 4095 ticks) are stored per channel. A write changes only the addressed channel, and it applies from the next cycle's visits.
- R9: Up to three lanes are processed in the same cycle, each on a different channel, with independent results.
- R10: After reset, every output bit is 0, and every counter, tick flag and configuration field is 0.
- R11: An output bit changes only at the clock edge ending a cycle in which its channel was visited. Ticks and configuration writes alone change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 0.1 ms |
| inValid | input | LANES | Per-lane sample valid |
| inCh | input | LANES*CHW | Per-lane channel number, lane 0 in the low bits |
| inLevel | input | LANES*LVL_W | Per-lane signed level, lane 0 in the low bits |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCh | input | CHW | Channel addressed by the write |
| cfgLow | input | LVL_W | Signed low threshold |
| cfgHigh | input | LVL_W | Signed high threshold |
| cfgDeb | input | DEB_W | Debounce length in ticks |
| bitsOut | output | NCH | Debounced bit of every channel |

## Verification
The assertions assume that two valid lanes in the same cycle never carry the same channel number. They also assume that every valid channel number is below the channel count. The read-modify-write has no merging path, so a repeated channel in one cycle would lose an update. The bench's random phase picks the lane channels from disjoint offsets around a random base, which keeps them distinct. Every directed step uses only legal channel numbers.

// File: rtl/lvl_deb_pkg.sv
package lvl_deb_pkg;
  // Strobes sent from control to datapath, one per lane.
  typedef struct packed {
    logic visit;    // lane carries a valid sample this cycle
    logic tickHit;  // a tick counts toward this visit's debounce
  } laneStrobe_t;
endpackage

// File: rtl/lvl_classify.sv
module lvl_classify #(
  parameter int LVL_W = 16
) (
  input  logic signed [LVL_W-1:0] level,
  input  logic signed [LVL_W-1:0] lowTh,
  input  logic signed [LVL_W-1:0] highTh,
  input  logic                    prevBit,
  output logic                    rawBit
);
  logic signed [LVL_W-1:0] effLow;

  always_comb begin
    // An inverted pair collapses to one threshold at the high value.
    effLow = (lowTh > highTh) ? highTh : lowTh;
    if (level > highTh)      rawBit = 1'b1;
    else if (level < effLow) rawBit = 1'b0;
    else                     rawBit = prevBit;
  end
endmodule

// File: rtl/lvl_deb_ctrl.sv
module lvl_deb_ctrl
  import lvl_deb_pkg::*;
#(
  parameter int NCH   = 48,
  parameter int LANES = 3,
  parameter int CHW   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [LANES-1:0]       inValid,
  input  logic [LANES*CHW-1:0]   inCh,
  output laneStrobe_t            strb [LANES]
);
  logic [NCH-1:0] tickFlag;
  logic [NCH-1:0] visitMask;
  logic [CHW-1:0] laneCh [LANES];

  for (genvar l = 0; l < LANES; l++) begin : gCh
    assign laneCh[l] = inCh[l*CHW +: CHW];
    assign strb[l].visit   = inValid[l];
    assign strb[l].tickHit = inValid[l] & (tick | tickFlag[laneCh[l]]);

    assert_ch_range_R9: assert property (@(posedge clk) disable iff (!rstN)
      inValid[l] |-> (int'(laneCh[l]) < NCH));

    for (genvar m = l + 1; m < LANES; m++) begin : gPair
      assert_lane_distinct_R9: assert property (@(posedge clk) disable iff (!rstN)
        (inValid[l] && inValid[m]) |-> (laneCh[l] != laneCh[m]));
    end
  end

  always_comb begin
    visitMask = '0;
    for (int l = 0; l < LANES; l++)
      if (inValid[l]) visitMask[laneCh[l]] = 1'b1;
  end

  // A visit consumes the flag; an unvisited channel remembers any tick.
  always_ff @(posedge clk) begin
    if (!rstN) tickFlag <= '0;
    else       tickFlag <= ~visitMask & (tickFlag | {NCH{tick}});
  end
endmodule

// File: rtl/lvl_deb_dp.sv
module lvl_deb_dp
  import lvl_deb_pkg::*;
#(
  parameter int NCH   = 48,
  parameter int LANES = 3,
  parameter int CHW   = 6,
  parameter int LVL_W = 16,
  parameter int DEB_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t             strb [LANES],
  input  logic [LANES*CHW-1:0]    inCh,
  input  logic [LANES*LVL_W-1:0]  inLevel,
  input  logic                    cfgWe,
  input  logic [CHW-1:0]          cfgCh,
  input  logic [LVL_W-1:0]        cfgLow,
  input  logic [LVL_W-1:0]        cfgHigh,
  input  logic [DEB_W-1:0]        cfgDeb,
  output logic [NCH-1:0]          bitsOut
);
  logic signed [LVL_W-1:0] loMem  [NCH];
  logic signed [LVL_W-1:0] hiMem  [NCH];
  logic        [DEB_W-1:0] debMem [NCH];
  logic        [DEB_W-1:0] cntMem [NCH];

  logic [CHW-1:0]          ch      [LANES];
  logic signed [LVL_W-1:0] lvl     [LANES];
  logic signed [LVL_W-1:0] lo      [LANES];
  logic signed [LVL_W-1:0] hi      [LANES];
  logic [DEB_W-1:0]        deb     [LANES];
  logic [DEB_W-1:0]        cntN    [LANES];
  logic [DEB_W-1:0]        nextCnt [LANES];
  logic                    cur     [LANES];
  logic                    raw     [LANES];
  logic                    nextOut [LANES];
  logic [LANES-1:0]        anyVisit;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign ch[l]  = inCh[l*CHW +: CHW];
    assign lvl[l] = $signed(inLevel[l*LVL_W +: LVL_W]);
    assign lo[l]  = loMem[ch[l]];
    assign hi[l]  = hiMem[ch[l]];
    assign deb[l] = debMem[ch[l]];
    assign cur[l] = bitsOut[ch[l]];
    assign anyVisit[l] = strb[l].visit;

    lvl_classify #(.LVL_W(LVL_W)) uCls (
      .level(lvl[l]), .lowTh(lo[l]), .highTh(hi[l]),
      .prevBit(cur[l]), .rawBit(raw[l])
    );

    always_comb begin
      cntN[l] = cntMem[ch[l]] + DEB_W'(strb[l].tickHit);
      if (deb[l] == '0) begin
        nextOut[l] = raw[l];
        nextCnt[l] = '0;
      end else if (raw[l] == cur[l]) begin
        nextOut[l] = cur[l];
        nextCnt[l] = '0;
      end else if (cntN[l] >= deb[l]) begin
        nextOut[l] = raw[l];
        nextCnt[l] = '0;
      end else begin
        nextOut[l] = cur[l];
        nextCnt[l] = cntN[l];
      end
    end

    // A rise is only possible for a level above the high threshold.
    assert_rise_above_high_R1: assert property (@(posedge clk) disable iff (!rstN)
      (strb[l].visit && !cur[l] && nextOut[l]) |-> (lvl[l] > hi[l]));
    // A fall is only possible for a level below the low threshold.
    assert_fall_below_low_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb[l].visit && cur[l] && !nextOut[l]) |-> (lvl[l] < lo[l]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsOut <= '0;
      for (int c = 0; c < NCH; c++) begin
        loMem[c]  <= '0;
        hiMem[c]  <= '0;
        debMem[c] <= '0;
        cntMem[c] <= '0;
      end
    end else begin
      if (cfgWe) begin
        loMem[cfgCh]  <= $signed(cfgLow);
        hiMem[cfgCh]  <= $signed(cfgHigh);
        debMem[cfgCh] <= cfgDeb;
      end
      for (int l = 0; l < LANES; l++) begin
        if (strb[l].visit) begin
          bitsOut[ch[l]] <= nextOut[l];
          cntMem[ch[l]]  <= nextCnt[l];
        end
      end
    end
  end

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (anyVisit == '0) |=> $stable(bitsOut));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (bitsOut == '0));
endmodule

// File: rtl/lvl_deb_top.sv
module lvl_deb_top
  import lvl_deb_pkg::*;
#(
  parameter int NCH   = 48,
  parameter int LANES = 3,
  parameter int LVL_W = 16,
  parameter int DEB_W = 12,
  parameter int CHW   = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES*CHW-1:0]    inCh,
  input  logic [LANES*LVL_W-1:0]  inLevel,
  input  logic                    cfgWe,
  input  logic [CHW-1:0]          cfgCh,
  input  logic [LVL_W-1:0]        cfgLow,
  input  logic [LVL_W-1:0]        cfgHigh,
  input  logic [DEB_W-1:0]        cfgDeb,
  output logic [NCH-1:0]          bitsOut
);
  laneStrobe_t strb [LANES];

  lvl_deb_ctrl #(.NCH(NCH), .LANES(LANES), .CHW(CHW)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .inValid(inValid), .inCh(inCh), .strb(strb)
  );

  lvl_deb_dp #(.NCH(NCH), .LANES(LANES), .CHW(CHW),
               .LVL_W(LVL_W), .DEB_W(DEB_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inCh(inCh), .inLevel(inLevel),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgLow(cfgLow),
    .cfgHigh(cfgHigh), .cfgDeb(cfgDeb), .bitsOut(bitsOut)
  );
endmodule

// File: tb/tb_lvl_deb_top.sv
module tb_lvl_deb_top;
  localparam int NCH = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  vld = '0;
  logic [17:0] chs = '0;
  logic [47:0] lvls = '0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgCh = '0;
  logic [15:0] cfgLow = '0;
  logic [15:0] cfgHigh = '0;
  logic [11:0] cfgDeb = '0;
  logic [47:0] bitsOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_deb_top dut (
    .clk(clk), .rstN(rstN), .tick(tick), .inValid(vld), .inCh(chs),
    .inLevel(lvls), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgLow(cfgLow),
    .cfgHigh(cfgHigh), .cfgDeb(cfgDeb), .bitsOut(bitsOut)
  );

  // Behavioural reference model
  int mLo[NCH], mHi[NCH], mDeb[NCH], mCnt[NCH];
  bit mOut[NCH], mFlag[NCH], mVis[NCH];
  int mc, mlv, mlo, mraw;
  bit mth;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mLo[c] = 0; mHi[c] = 0; mDeb[c] = 0; mCnt[c] = 0;
        mOut[c] = 0; mFlag[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) mVis[c] = 0;
      for (int l = 0; l < 3; l++) begin
        if (vld[l]) begin
          mc  = int'(chs[l*6 +: 6]);
          mlv = int'($signed(lvls[l*16 +: 16]));
          mlo = (mLo[mc] > mHi[mc]) ? mHi[mc] : mLo[mc];
          if (mlv > mHi[mc])  mraw = 1;
          else if (mlv < mlo) mraw = 0;
          else                mraw = int'(mOut[mc]);
          mth = tick || mFlag[mc];
          if (mDeb[mc] == 0) begin
            mOut[mc] = (mraw != 0); mCnt[mc] = 0;
          end else if ((mraw != 0) == mOut[mc]) begin
            mCnt[mc] = 0;
          end else begin
            mCnt[mc] = mCnt[mc] + (mth ? 1 : 0);
            if (mCnt[mc] >= mDeb[mc]) begin
              mOut[mc] = (mraw != 0); mCnt[mc] = 0;
            end
          end
          mVis[mc] = 1;
        end
      end
      for (int c = 0; c < NCH; c++) mFlag[c] = mVis[c] ? 1'b0 : (mFlag[c] || tick);
      if (cfgWe) begin
        mLo[cfgCh]  = int'($signed(cfgLow));
        mHi[cfgCh]  = int'($signed(cfgHigh));
        mDeb[cfgCh] = int'(cfgDeb);
      end
    end
  end

  // Compare the whole output with the model on every cycle.
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (bitsOut[c] !== mOut[c]) begin
          fails++;
          $display("FAIL R9 model ch%0d: actual %0b expected %0b", c, bitsOut[c], mOut[c]);
        end
      end
    end
  end

  task automatic chk(input int ch, input bit exp, input string tag);
    checks++;
    if (bitsOut[ch] !== exp) begin
      fails++;
      $display("FAIL %s ch%0d: actual %0b expected %0b", tag, ch, bitsOut[ch], exp);
    end
  endtask

  task automatic step(input logic [2:0] v, input int c0, input int c1, input int c2,
                      input int l0, input int l1, input int l2, input bit tk);
    vld = v;
    chs = {c2[5:0], c1[5:0], c0[5:0]};
    lvls = {l2[15:0], l1[15:0], l0[15:0]};
    tick = tk;
    @(negedge clk);
    vld = '0;
    tick = 1'b0;
  endtask

  task automatic one(input int ch, input int lv, input bit tk);
    step(3'b001, ch, 0, 0, lv, 0, 0, tk);
  endtask

  task automatic tickOnly();
    step(3'b000, 0, 0, 0, 0, 0, 0, 1'b1);
  endtask

  task automatic setCfg(input int ch, input int lo, input int hi, input int db);
    cfgWe = 1'b1; cfgCh = ch[5:0]; cfgLow = lo[15:0]; cfgHigh = hi[15:0]; cfgDeb = db[11:0];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int b, c0, c1, c2;
    logic [47:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (bitsOut !== '0) begin
      fails++;
      $display("FAIL R10 reset: actual %h expected 0", bitsOut);
    end

    // R1 R2 R3 R5: plain band, no debounce
    setCfg(0, 100, 200, 0);
    one(0, 250, 0); chk(0, 1, "R1/R5");
    one(0, 150, 0); chk(0, 1, "R3");
    one(0, 200, 0); chk(0, 1, "R3 edge");
    one(0, 50, 0);  chk(0, 0, "R2");
    one(0, 100, 0); chk(0, 0, "R3 edge low");
    one(0, -30000, 0); chk(0, 0, "R2 negative");

    // R4: inverted pair acts as one threshold at high
    setCfg(1, 300, 100, 0);
    one(1, 150, 0); chk(1, 1, "R4 above");
    one(1, 100, 0); chk(1, 1, "R4 equal holds");
    one(1, 50, 0);  chk(1, 0, "R4 below");

    // R6: debounce of 3 ticks
    setCfg(2, 0, 10, 3);
    one(2, 20, 0); chk(2, 0, "R6 no tick");
    tickOnly(); one(2, 20, 0); chk(2, 0, "R6 count1");
    tickOnly(); one(2, 20, 0); chk(2, 0, "R6 count2");
    one(2, 20, 1); chk(2, 1, "R6 count3 same-cycle tick");

    // R7: agreement clears the counter
    tickOnly(); one(2, -5, 0);
    tickOnly(); one(2, 5, 0);
    tickOnly(); one(2, -5, 0);
    tickOnly(); one(2, -5, 0); chk(2, 1, "R7 cleared count");
    tickOnly(); one(2, -5, 0); chk(2, 0, "R7 flip after full count");

    // R9: three lanes at once
    setCfg(3, 0, 0, 0); setCfg(4, 0, 0, 0); setCfg(5, 0, 0, 0);
    step(3'b111, 3, 4, 5, 5, -5, 5, 0);
    chk(3, 1, "R9 lane0"); chk(4, 0, "R9 lane1"); chk(5, 1, "R9 lane2");

    // R8: per-channel config
    setCfg(3, 0, 1000, 0);
    one(3, 500, 0); chk(3, 1, "R8 new band holds");
    one(4, 5, 0);   chk(4, 1, "R8 other channel keeps old config");
    one(3, -1, 0);  chk(3, 0, "R8 below new low");

    // R11: ticks and config writes alone change nothing
    snap = bitsOut;
    tickOnly(); tickOnly();
    setCfg(0, -500, -400, 0);
    checks++;
    if (bitsOut !== snap) begin
      fails++;
      $display("FAIL R11 idle: actual %h expected %h", bitsOut, snap);
    end

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) begin
        cfgWe = 1'b1;
        cfgCh = 6'($urandom_range(NCH - 1));
        cfgLow = 16'(int'($urandom_range(400)) - 200);
        cfgHigh = 16'(int'($urandom_range(400)) - 200);
        cfgDeb = 12'($urandom_range(4));
      end
      b  = int'($urandom_range(NCH - 1));
      c0 = b;
      c1 = (b + 1 + int'($urandom_range(14))) % NCH;
      c2 = (b + 17 + int'($urandom_range(14))) % NCH;
      step(3'($urandom_range(7)), c0, c1, c2,
           int'($urandom_range(600)) - 300, int'($urandom_range(600)) - 300,
           int'($urandom_range(600)) - 300, ($urandom_range(3) == 0));
      cfgWe = 1'b0;
    end
    finishRun();
  end
endmodule